// File: doc/BRIEF.md
# Segmented Page Translation Lookaside Buffer

This block performs the second stage of address translation for a 32-bit memory management unit. The top bits of an effective address select one of sixteen segment registers. The selected register supplies a virtual segment identifier, two protection keys and a no-execute flag. The identifier and the page field of the address then index and tag-match a 64-entry direct-mapped page TLB. Each entry holds a real page number and two page-protection bits.

Every request returns, one cycle later, exactly one of three outcomes. A hit carries the real address. A miss means the page table must be walked. A fault is a protection violation. The block also returns the primary and secondary hash values that a walker needs to find the page-table group, but the walk itself happens outside. Software or a walker loads segment registers through a write port and TLB entries through a fill port. A flush input drops every TLB entry in one cycle.

Top module: `seg_page_tlb`

## Requirements
- R1: After reset all TLB entries are invalid, every segment register reads as zero (both keys 0, execution allowed, identifier 0), and rsp_valid, rsp_hit, rsp_miss and rsp_fault are low.
- R2: A request sampled with req_valid high at a clock edge produces rsp_valid high after that edge, with exactly one of rsp_hit, rsp_miss or rsp_fault high. When req_valid was low, all four are low.
- R3: The segment register is selected by req_ea[31:28]. In a segment register, bit 30 is the supervisor key, bit 29 is the problem key, bit 28 is no-execute, and bits [23:0] are the virtual segment identifier. Bits 27..24 have no effect.
- R4: A segment register write whose bit 31 is set is discarded, and the register keeps its previous contents.
- R5: Access codes on req_acc are 00 read, 01 write and 10 fetch. A fetch through a segment whose no-execute bit is set faults. Reads and writes through that segment are not affected by the bit.
- R6: The TLB entry is chosen by req_ea[17:12]. It hits only if it is valid, its stored identifier equals the segment identifier, and its stored page equals req_ea[27:12]. Otherwise the result is a miss.
- R7: On a hit rsp_ra is {stored real page number, req_ea[11:0]}. On a miss or a fault rsp_ra is zero.
- R8: The key in force is the problem key when req_problem is high, and the supervisor key otherwise.
- R9: With key 0, every access is allowed for protection values 00, 01 and 10, and only read and fetch are allowed for 11. With key 1, nothing is allowed for 00, read and fetch are allowed for 01 and 11, and everything is allowed for 10. A denied access faults.
- R10: The checks are ranked in this order: a no-execute fault first, then a miss, then a protection fault.
- R11: With each response, rsp_hash_pri is the segment identifier XOR the zero-extended 16-bit page field, and rsp_hash_sec is its bitwise complement.
- R12: A fill writes one entry and makes it valid. A flush invalidates all entries, and it wins over a fill in the same cycle.
- R13: A request in the same cycle as a fill, a flush or a segment write is resolved against the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_wr_en | input | 1 | Segment register write strobe |
| sr_wr_idx | input | 4 | Segment register number |
| sr_wr_data | input | 32 | Segment register value |
| fill_en | input | 1 | TLB fill strobe |
| fill_idx | input | 6 | TLB entry to fill |
| fill_vsid | input | 24 | Virtual segment identifier tag |
| fill_page | input | 16 | Page tag |
| fill_rpn | input | 20 | Real page number |
| fill_pp | input | 2 | Page protection bits |
| flush | input | 1 | Invalidate all TLB entries |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type (00 read, 01 write, 10 fetch) |
| req_problem | input | 1 | Problem (user) state |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Page table walk needed |
| rsp_fault | output | 1 | Protection violation |
| rsp_ra | output | 32 | Real address on hit |
| rsp_hash_pri | output | 24 | Primary page-table hash |
| rsp_hash_sec | output | 24 | Secondary page-table hash |

## Verification
The hardest case to reach from the ports is a request that collides with a fill, a flush or a segment write to the state it reads. In that case the response must reflect the old contents, while the next request sees the new ones. Fill-plus-flush in one cycle falls under the same case. The stimulus drives these collisions directly. Random phases are biased so that lookups reuse the tag and segment identifier of valid entries, which gives a steady mix of hits, protection faults and near-miss tags. Every pairing of key, protection value, access type and state is also walked exhaustively.

// File: rtl/seg_tlb_pkg.sv
package seg_tlb_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10
   } acc_e;

   // Key-indexed page protection: returns 1 when the access is allowed.
   function automatic logic prot_allows(input logic key, input logic [1:0] pp,
                                        input logic [1:0] acc);
      if (acc == ACC_WRITE)
         return key ? (pp == 2'b10) : (pp != 2'b11);
      else
         return key ? (pp != 2'b00) : 1'b1;
   endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int SEG_IDX_W = 4,
   parameter int SR_W      = 32,
   parameter int VSID_W    = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEG_IDX_W-1:0] wr_idx,
   input  logic [SR_W-1:0]      wr_data,
   input  logic [SEG_IDX_W-1:0] rd_idx,
   output logic                 rd_key_sup,
   output logic                 rd_key_prob,
   output logic                 rd_no_exec,
   output logic [VSID_W-1:0]    rd_vsid
);
   localparam int NUM_SEG = 1 << SEG_IDX_W;
   localparam int T_POS   = SR_W - 1;
   localparam int KS_POS  = SR_W - 2;
   localparam int KP_POS  = SR_W - 3;
   localparam int NX_POS  = SR_W - 4;
   localparam int FLD_W   = VSID_W + 3;

   logic [FLD_W-1:0] seg_arr [NUM_SEG];
   logic             accept;
   logic [FLD_W-1:0] packed_wr;
   logic             unused_rsvd;

   assign accept      = wr_en & ~wr_data[T_POS];
   assign packed_wr   = {wr_data[KS_POS], wr_data[KP_POS], wr_data[NX_POS],
                         wr_data[VSID_W-1:0]};
   assign unused_rsvd = ^wr_data[NX_POS-1:VSID_W];

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      logic [FLD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (accept && wr_idx == SEG_IDX_W'(g))
            q <= packed_wr;
      end
      assign seg_arr[g] = q;
   end

   logic [FLD_W-1:0] sel;
   assign sel         = seg_arr[rd_idx];
   assign rd_key_sup  = sel[FLD_W-1];
   assign rd_key_prob = sel[FLD_W-2];
   assign rd_no_exec  = sel[FLD_W-3];
   assign rd_vsid     = sel[VSID_W-1:0];
endmodule

// File: rtl/page_tlb_array.sv
module page_tlb_array #(
   parameter int IDX_W  = 6,
   parameter int VSID_W = 24,
   parameter int PAGE_W = 16,
   parameter int RPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [VSID_W-1:0] fill_vsid,
   input  logic [PAGE_W-1:0] fill_page,
   input  logic [RPN_W-1:0]  fill_rpn,
   input  logic [1:0]        fill_pp,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [VSID_W-1:0] rd_vsid,
   output logic [PAGE_W-1:0] rd_page,
   output logic [RPN_W-1:0]  rd_rpn,
   output logic [1:0]        rd_pp
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [ENTRIES-1:0] valid_vec;
   logic [VSID_W-1:0]  vsid_q [ENTRIES];
   logic [PAGE_W-1:0]  page_q [ENTRIES];
   logic [RPN_W-1:0]   rpn_q  [ENTRIES];
   logic [1:0]         pp_q   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_vec[e] <= 1'b0;
         else if (flush)
            valid_vec[e] <= 1'b0;
         else if (fill_en && fill_idx == IDX_W'(e))
            valid_vec[e] <= 1'b1;
      end
   end

   // Payload carries no reset: the valid bit alone qualifies it.
   always_ff @(posedge clk) begin
      if (fill_en) begin
         vsid_q[fill_idx] <= fill_vsid;
         page_q[fill_idx] <= fill_page;
         rpn_q[fill_idx]  <= fill_rpn;
         pp_q[fill_idx]   <= fill_pp;
      end
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_vsid  = vsid_q[rd_idx];
   assign rd_page  = page_q[rd_idx];
   assign rd_rpn   = rpn_q[rd_idx];
   assign rd_pp    = pp_q[rd_idx];
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
   import seg_tlb_pkg::*;
#(
   parameter int VSID_W = 24,
   parameter int PAGE_W = 16,
   parameter int RPN_W  = 20,
   parameter int OFF_W  = 12
) (
   input  logic [1:0]         acc,
   input  logic               problem,
   input  logic               key_sup,
   input  logic               key_prob,
   input  logic               no_exec,
   input  logic [VSID_W-1:0]  seg_vsid,
   input  logic [PAGE_W-1:0]  ea_page,
   input  logic [OFF_W-1:0]   ea_off,
   input  logic               e_valid,
   input  logic [VSID_W-1:0]  e_vsid,
   input  logic [PAGE_W-1:0]  e_page,
   input  logic [RPN_W-1:0]   e_rpn,
   input  logic [1:0]         e_pp,
   output logic               hit,
   output logic               miss,
   output logic               fault,
   output logic [RPN_W+OFF_W-1:0] ra,
   output logic [VSID_W-1:0]  hash_pri
);
   logic nx_block, tag_ok, key_sel, granted;

   assign nx_block = no_exec && (acc == ACC_FETCH);
   assign tag_ok   = e_valid && (e_vsid == seg_vsid) && (e_page == ea_page);
   assign key_sel  = problem ? key_prob : key_sup;
   assign granted  = prot_allows(key_sel, e_pp, acc);
   assign hash_pri = seg_vsid ^ VSID_W'(ea_page);

   always_comb begin
      hit   = 1'b0;
      miss  = 1'b0;
      fault = 1'b0;
      if (nx_block)     fault = 1'b1;
      else if (!tag_ok) miss  = 1'b1;
      else if (!granted) fault = 1'b1;
      else              hit   = 1'b1;
   end

   assign ra = hit ? {e_rpn, ea_off} : '0;
endmodule

// File: rtl/seg_page_tlb.sv
module seg_page_tlb #(
   parameter int EA_W      = 32,
   parameter int SEG_IDX_W = 4,
   parameter int TLB_IDX_W = 6,
   parameter int OFF_W     = 12,
   parameter int VSID_W    = 24,
   parameter int SR_W      = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sr_wr_en,
   input  logic [SEG_IDX_W-1:0]       sr_wr_idx,
   input  logic [SR_W-1:0]            sr_wr_data,
   input  logic                       fill_en,
   input  logic [TLB_IDX_W-1:0]       fill_idx,
   input  logic [VSID_W-1:0]          fill_vsid,
   input  logic [EA_W-SEG_IDX_W-OFF_W-1:0] fill_page,
   input  logic [EA_W-OFF_W-1:0]      fill_rpn,
   input  logic [1:0]                 fill_pp,
   input  logic                       flush,
   input  logic                       req_valid,
   input  logic [EA_W-1:0]            req_ea,
   input  logic [1:0]                 req_acc,
   input  logic                       req_problem,
   output logic                       rsp_valid,
   output logic                       rsp_hit,
   output logic                       rsp_miss,
   output logic                       rsp_fault,
   output logic [EA_W-1:0]            rsp_ra,
   output logic [VSID_W-1:0]          rsp_hash_pri,
   output logic [VSID_W-1:0]          rsp_hash_sec
);
   localparam int PAGE_W = EA_W - SEG_IDX_W - OFF_W;
   localparam int RPN_W  = EA_W - OFF_W;

   logic [SEG_IDX_W-1:0] seg_idx;
   logic [PAGE_W-1:0]    page;
   logic [TLB_IDX_W-1:0] tlb_idx;

   assign seg_idx = req_ea[EA_W-1 -: SEG_IDX_W];
   assign page    = req_ea[EA_W-SEG_IDX_W-1:OFF_W];
   assign tlb_idx = req_ea[OFF_W+TLB_IDX_W-1:OFF_W];

   logic              s_ks, s_kp, s_nx;
   logic [VSID_W-1:0] s_vsid;

   seg_regfile #(.SEG_IDX_W(SEG_IDX_W), .SR_W(SR_W), .VSID_W(VSID_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .wr_en(sr_wr_en), .wr_idx(sr_wr_idx),
      .wr_data(sr_wr_data), .rd_idx(seg_idx), .rd_key_sup(s_ks),
      .rd_key_prob(s_kp), .rd_no_exec(s_nx), .rd_vsid(s_vsid));

   logic              e_valid;
   logic [VSID_W-1:0] e_vsid;
   logic [PAGE_W-1:0] e_page;
   logic [RPN_W-1:0]  e_rpn;
   logic [1:0]        e_pp;

   page_tlb_array #(.IDX_W(TLB_IDX_W), .VSID_W(VSID_W), .PAGE_W(PAGE_W),
                    .RPN_W(RPN_W)) u_tlb (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
      .fill_idx(fill_idx), .fill_vsid(fill_vsid), .fill_page(fill_page),
      .fill_rpn(fill_rpn), .fill_pp(fill_pp), .rd_idx(tlb_idx),
      .rd_valid(e_valid), .rd_vsid(e_vsid), .rd_page(e_page),
      .rd_rpn(e_rpn), .rd_pp(e_pp));

   logic              c_hit, c_miss, c_fault;
   logic [EA_W-1:0]   c_ra;
   logic [VSID_W-1:0] c_hash;

   tlb_resolve #(.VSID_W(VSID_W), .PAGE_W(PAGE_W), .RPN_W(RPN_W),
                 .OFF_W(OFF_W)) u_res (
      .acc(req_acc), .problem(req_problem), .key_sup(s_ks), .key_prob(s_kp),
      .no_exec(s_nx), .seg_vsid(s_vsid), .ea_page(page),
      .ea_off(req_ea[OFF_W-1:0]), .e_valid(e_valid), .e_vsid(e_vsid),
      .e_page(e_page), .e_rpn(e_rpn), .e_pp(e_pp), .hit(c_hit),
      .miss(c_miss), .fault(c_fault), .ra(c_ra), .hash_pri(c_hash));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_ra       <= '0;
         rsp_hash_pri <= '0;
         rsp_hash_sec <= '0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_hit      <= req_valid & c_hit;
         rsp_miss     <= req_valid & c_miss;
         rsp_fault    <= req_valid & c_fault;
         rsp_ra       <= req_valid ? c_ra : '0;
         rsp_hash_pri <= req_valid ? c_hash : '0;
         rsp_hash_sec <= req_valid ? ~c_hash : '0;
      end
   end
endmodule

// File: rtl/seg_page_tlb_chk.sv
module seg_page_tlb_chk #(
   parameter int EA_W      = 32,
   parameter int SEG_IDX_W = 4,
   parameter int TLB_IDX_W = 6,
   parameter int OFF_W     = 12,
   parameter int VSID_W    = 24,
   parameter int SR_W      = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [EA_W-1:0] req_ea,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic            rsp_miss,
   input logic            rsp_fault,
   input logic [EA_W-1:0] rsp_ra
);
   localparam int PAGE_W = EA_W - SEG_IDX_W - OFF_W;

   initial begin
      AST_GEOMETRY: assert (TLB_IDX_W <= PAGE_W && VSID_W >= PAGE_W
                            && SR_W >= VSID_W + 4 && PAGE_W > 0); // R6
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R2
   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_ra[OFF_W-1:0] == $past(req_ea[OFF_W-1:0])); // R7
   AST_NOHIT_RA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_ra == '0); // R7
endmodule

bind seg_page_tlb seg_page_tlb_chk #(
   .EA_W(EA_W), .SEG_IDX_W(SEG_IDX_W), .TLB_IDX_W(TLB_IDX_W),
   .OFF_W(OFF_W), .VSID_W(VSID_W), .SR_W(SR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
   .rsp_fault(rsp_fault), .rsp_ra(rsp_ra));

// File: tb/seg_page_tlb_test.sv
module seg_page_tlb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_wr_en = 0;
   logic [3:0]  sr_wr_idx = 0;
   logic [31:0] sr_wr_data = 0;
   logic        fill_en = 0;
   logic [5:0]  fill_idx = 0;
   logic [23:0] fill_vsid = 0;
   logic [15:0] fill_page = 0;
   logic [19:0] fill_rpn = 0;
   logic [1:0]  fill_pp = 0;
   logic        flush = 0;
   logic        req_valid = 0;
   logic [31:0] req_ea = 0;
   logic [1:0]  req_acc = 0;
   logic        req_problem = 0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
   logic [31:0] rsp_ra;
   logic [23:0] rsp_hash_pri, rsp_hash_sec;

   always #5 clk = ~clk;

   seg_page_tlb uut (
      .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_idx(sr_wr_idx),
      .sr_wr_data(sr_wr_data), .fill_en(fill_en), .fill_idx(fill_idx),
      .fill_vsid(fill_vsid), .fill_page(fill_page), .fill_rpn(fill_rpn),
      .fill_pp(fill_pp), .flush(flush), .req_valid(req_valid),
      .req_ea(req_ea), .req_acc(req_acc), .req_problem(req_problem),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .rsp_ra(rsp_ra), .rsp_hash_pri(rsp_hash_pri),
      .rsp_hash_sec(rsp_hash_sec));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // Reference model
   logic [31:0] m_sr   [16];
   logic        m_v    [64];
   logic [23:0] m_vsid [64];
   logic [15:0] m_page [64];
   logic [19:0] m_rpn  [64];
   logic [1:0]  m_pp   [64];

   function automatic void predict(input logic [31:0] ea, input logic [1:0] acc,
                                   input logic prob, output logic h,
                                   output logic m, output logic f,
                                   output logic [31:0] ra, output logic [23:0] hp);
      logic [31:0] sr;
      logic [5:0]  ix;
      logic        key, ok;
      sr  = m_sr[ea[31:28]];
      ix  = ea[17:12];
      key = prob ? sr[29] : sr[30];
      hp  = sr[23:0] ^ {8'h00, ea[27:12]};
      h = 0; m = 0; f = 0; ra = 0;
      case ({key, m_pp[ix]})
         3'b000, 3'b001, 3'b010: ok = 1'b1;
         3'b011:                 ok = (acc != 2'b01);
         3'b100:                 ok = 1'b0;
         3'b110:                 ok = 1'b1;
         default:                ok = (acc != 2'b01);
      endcase
      if (acc == 2'b10 && sr[28]) f = 1;
      else if (!(m_v[ix] && m_vsid[ix] == sr[23:0] && m_page[ix] == ea[27:12])) m = 1;
      else if (!ok) f = 1;
      else begin
         h = 1;
         ra = {m_rpn[ix], ea[11:0]};
      end
   endfunction

   task automatic step(input string rq);
      logic e_v, e_h, e_m, e_f;
      logic [31:0] e_ra;
      logic [23:0] e_hp;
      e_v = req_valid;
      predict(req_ea, req_acc, req_problem, e_h, e_m, e_f, e_ra, e_hp);
      @(posedge clk);
      if (sr_wr_en && !sr_wr_data[31]) m_sr[sr_wr_idx] = sr_wr_data;
      if (flush) begin
         for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
      end else if (fill_en) begin
         m_v[fill_idx] = 1'b1;     m_vsid[fill_idx] = fill_vsid;
         m_page[fill_idx] = fill_page; m_rpn[fill_idx] = fill_rpn;
         m_pp[fill_idx] = fill_pp;
      end
      @(negedge clk);
      n_chk++;
      if (e_v) begin
         if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ra, rsp_hash_pri, rsp_hash_sec}
             !== {1'b1, e_h, e_m, e_f, e_ra, e_hp, ~e_hp}) begin
            n_bad++;
            $display("FAIL %s: got v%0b h%0b m%0b f%0b ra=%h hp=%h hs=%h, expected v1 h%0b m%0b f%0b ra=%h hp=%h hs=%h",
                     rq, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ra, rsp_hash_pri,
                     rsp_hash_sec, e_h, e_m, e_f, e_ra, e_hp, ~e_hp);
         end
      end else if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault} !== 4'b0) begin
         n_bad++;
         $display("FAIL %s: idle flags got %b expected 0000", rq,
                  {rsp_valid, rsp_hit, rsp_miss, rsp_fault});
      end
      sr_wr_en = 0; fill_en = 0; flush = 0; req_valid = 0;
   endtask

   task automatic wr_seg(input logic [3:0] ix, input logic [31:0] d, input string rq);
      sr_wr_en = 1; sr_wr_idx = ix; sr_wr_data = d;
      step(rq);
   endtask

   task automatic set_fill(input logic [5:0] ix, input logic [23:0] vs,
                           input logic [15:0] pg, input logic [19:0] rp,
                           input logic [1:0] pp);
      fill_en = 1; fill_idx = ix; fill_vsid = vs; fill_page = pg;
      fill_rpn = rp; fill_pp = pp;
   endtask

   task automatic set_req(input logic [31:0] ea, input logic [1:0] acc, input logic pr);
      req_valid = 1; req_ea = ea; req_acc = acc; req_problem = pr;
   endtask

   task automatic look(input logic [31:0] ea, input logic [1:0] acc,
                       input logic pr, input string rq);
      set_req(ea, acc, pr);
      step(rq);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < 16; i++) m_sr[i] = 0;
      for (int i = 0; i < 64; i++) begin
         m_v[i] = 0; m_vsid[i] = 0; m_page[i] = 0; m_rpn[i] = 0; m_pp[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset, empty TLB, zero segment registers
      step("R1");
      look(32'h1234_5678, 2'b00, 1'b0, "R1");
      look(32'hF000_0ABC, 2'b10, 1'b1, "R1 R11");

      // R3 R4: segment format, T-bit write discarded
      wr_seg(4'h3, 32'h0F00_00AB, "R3");
      wr_seg(4'h3, 32'h8000_0CDE, "R4");
      set_fill(6'h05, 24'h0000AB, 16'h1005, 20'hABCDE, 2'b10);
      step("R12");
      look(32'h3100_5123, 2'b01, 1'b0, "R4 R6 R7");
      look(32'h3100_5FFF, 2'b00, 1'b1, "R3 R7");
      // R6: tag mismatches on the same index
      look(32'h3200_5123, 2'b00, 1'b0, "R6 page");
      look(32'h4100_5123, 2'b00, 1'b0, "R6 vsid");

      // R5 R10: no-execute segment
      wr_seg(4'h4, 32'h1000_0011, "R5");
      look(32'h4777_7000, 2'b10, 1'b0, "R5 R10 nx before miss");
      set_fill(6'h37, 24'h000011, 16'h7777, 20'h13579, 2'b10);
      step("R12");
      look(32'h4777_7010, 2'b00, 1'b0, "R5 read");
      look(32'h4777_7020, 2'b01, 1'b1, "R5 write");
      look(32'h4777_7030, 2'b10, 1'b0, "R5 fetch");

      // R8 R9 R10: full protection table
      for (int k = 0; k < 2; k++) begin
         for (int pp = 0; pp < 4; pp++) begin
            wr_seg(4'h5, {1'b0, k[0], ~k[0], 1'b0, 28'h0000055}, "R8");
            set_fill(6'h07, 24'h000055, 16'h0007, 20'h0F0F0 + 20'(pp), pp[1:0]);
            step("R12");
            for (int a = 0; a < 3; a++) begin
               for (int p = 0; p < 2; p++)
                  look(32'h5000_73C4, a[1:0], p[0], "R8 R9");
               look(32'h5001_73C4, a[1:0], 1'b0, "R10 miss before prot");
            end
         end
      end

      // R12: flush wins over fill
      set_fill(6'h09, 24'h0000AB, 16'h0009, 20'h22222, 2'b10);
      flush = 1;
      step("R12 flush+fill");
      look(32'h3000_9000, 2'b00, 1'b0, "R12 flushed");
      look(32'h3100_5123, 2'b00, 1'b0, "R12 old entry gone");

      // R13: same-cycle fill / segment write / flush
      set_fill(6'h0A, 24'h0000AB, 16'h000A, 20'h33333, 2'b10);
      set_req(32'h3000_A444, 2'b00, 1'b0);
      step("R13 fill");
      look(32'h3000_A444, 2'b00, 1'b0, "R13 after fill");
      sr_wr_en = 1; sr_wr_idx = 4'h3; sr_wr_data = 32'h0000_00CD;
      set_req(32'h3000_A444, 2'b00, 1'b0);
      step("R13 seg write");
      look(32'h3000_A444, 2'b00, 1'b0, "R13 after seg write");
      wr_seg(4'h3, 32'h0000_00AB, "R3");
      flush = 1;
      set_req(32'h3000_A444, 2'b00, 1'b0);
      step("R13 flush");
      look(32'h3000_A444, 2'b00, 1'b0, "R13 after flush");

      // Random phase
      for (int i = 0; i < 16; i++)
         wr_seg(4'(i), {1'b0, 3'($urandom), 25'h0, 3'($urandom)}, "R3");
      for (int it = 0; it < 4000; it++) begin
         int r;
         r = int'($urandom % 16);
         if (r == 0) begin
            sr_wr_en = 1; sr_wr_idx = 4'($urandom);
            sr_wr_data = {($urandom % 4 == 0), 3'($urandom), 4'($urandom), 21'h0, 3'($urandom)};
         end
         if (r >= 1 && r <= 4) begin
            logic [15:0] pg;
            pg = 16'($urandom % 8) << 6 | 16'($urandom % 64);
            set_fill(pg[5:0], m_sr[4'($urandom)][23:0], pg, 20'($urandom), 2'($urandom));
         end
         if ($urandom % 128 == 0) flush = 1;
         if (r >= 4) begin
            logic [31:0] ea;
            int ix;
            ea = {4'($urandom), 16'($urandom % 8) << 6 | 16'($urandom % 64), 12'($urandom)};
            ix = int'($urandom % 64);
            if (m_v[ix] && $urandom % 4 != 0) begin
               for (int s = 0; s < 16; s++)
                  if (m_sr[s][23:0] == m_vsid[ix]) ea = {4'(s), m_page[ix], 12'($urandom)};
            end
            set_req(ea, 2'($urandom % 3), 1'($urandom));
         end
         step("R2 R5 R6 R7 R9 R11 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule